// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block decides whether a received frame with a group destination address is accepted. The destination address arrives one byte per accepted beat, first-transmitted byte first, with a start flag on the first byte. The block runs the Ethernet CRC-32 over the six bytes, feeding each byte least significant bit first. From the CRC it forms an 8-bit hash index. It then looks that index up in a 256-entry bit table. The table is held in eight 32-bit registers that software writes and reads.

The input stream is qualified by `in_valid` alone and has no back-pressure. The block accepts a byte in every cycle that `in_valid` is high, so an upstream source never has to wait. Idle cycles with `in_valid` low may fall anywhere inside an address. Software changes single table bits by reading a whole register through the read port, editing it, and writing the whole register back.

The decision appears as a one-cycle `dec_valid` pulse together with a group flag and an accept flag. A frame whose first byte has bit 0 clear is reported as not a group frame, and no table lookup is made for it.

Top module: `mhf_group_filter`

## Requirements
- R1: After reset all eight table registers read as zero, `dec_valid` is low, and a group address sent right after reset is rejected.
- R2: The hash index is computed as follows. Seed a CRC-32 (polynomial 0x04C11DB7, no final inversion) with all ones. Shift in the six address bytes in arrival order, each byte bit 0 first. The index is the top 8 bits of that register, which is the same as the low 8 bits, bit-reversed, of the reflected 0xEDB88320 form.
- R3: Hash index i maps to table register i[7:5] and to bit position 31 − i[4:0] of that register. Index 0 is bit 31 of register 0, and index 255 is bit 0 of register 7.
- R4: `dec_valid` is high for exactly the one cycle that follows the cycle in which the sixth byte is accepted. `dec_group` and `dec_accept` are low whenever `dec_valid` is low.
- R5: If bit 0 of the first byte is 0, the decision shows `dec_group` = 0 and `dec_accept` = 0, whatever the table holds.
- R6: For a group address, `dec_accept` equals the table bit that R2 and R3 select.
- R7: `in_start` with `in_valid` restarts the CRC from all ones and takes the current byte as byte 1. A partly received address is dropped without a decision.
- R8: Cycles with `in_valid` low are skipped. Bytes without `in_start` that arrive while no address is in progress are ignored and produce no decision.
- R9: A register write replaces all 32 bits. The read port returns the stored value combinationally, starting in the cycle after the write.
- R10: A write made in the cycle that accepts the sixth byte does not affect that decision. It applies from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Address byte present this cycle |
| in_start | input | 1 | Byte is the first byte of an address |
| in_data | input | 8 | Address byte |
| reg_wr_en | input | 1 | Table register write strobe |
| reg_wr_addr | input | 3 | Table register written |
| reg_wdata | input | 32 | Write data (whole register) |
| reg_rd_addr | input | 3 | Table register read |
| reg_rdata | output | 32 | Read data |
| dec_valid | output | 1 | Decision strobe |
| dec_group | output | 1 | Address was a group address |
| dec_accept | output | 1 | Group address hit a set table bit |

## Verification
Some properties are checked on every cycle: the decision strobe lasting one cycle, the strobe always following an accepted byte, the flags staying quiet outside the strobe, non-group addresses never being accepted, and a written word reading back one cycle later. Other behaviour can only be shown by the bench's scenarios, because it needs a reference hash computed in the bench. This covers the CRC and bit-reversal, the MSB-first bit mapping, restart on a new start flag, stray bytes being dropped, and the ordering of a write against a lookup in the same cycle.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;
  // Ethernet generator in shift-left form; bits enter LSB first
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = '1;
endpackage

// File: rtl/mhf_crc_byte.sv
// One byte of CRC update, unrolled bit by bit, bit 0 of the byte first.
module mhf_crc_byte
  import mhf_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [BYTE_W:0][CRC_W-1:0] stage;

  assign stage[0] = crc_i;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][CRC_W-1] ^ byte_i[b];
    assign stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/mhf_addr_seq.sv
// Collects the address bytes and keeps the running CRC and group bit.
module mhf_addr_seq
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [BYTE_W-1:0] in_data,
  output logic              fin_o,
  output logic              grp_o,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CRC_W-1:0] crc_q, seed, crc_nxt;
  logic             grp_q;
  logic             busy, take;

  assign busy = (cnt_q != '0) && (cnt_q < CNT_W'(ADDR_BYTES));
  assign take = in_valid && (in_start || busy);
  assign seed = in_start ? CRC_SEED : crc_q;

  mhf_crc_byte u_crc (
    .crc_i  (seed),
    .byte_i (in_data),
    .crc_o  (crc_nxt)
  );

  assign cnt_nxt = in_start ? CNT_W'(1) : cnt_q + CNT_W'(1);
  assign grp_o   = in_start ? in_data[0] : grp_q;
  assign fin_o   = take && (cnt_nxt == CNT_W'(ADDR_BYTES));
  assign crc_o   = crc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
      grp_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_nxt;
      crc_q <= crc_nxt;
      grp_q <= grp_o;
    end
  end
endmodule

// File: rtl/mhf_hash_table.sv
// Bit table in NUM_REGS words; entry numbering is MSB-first inside a word.
module mhf_hash_table #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int BIT_W   = $clog2(REG_W),
  localparam int HASH_W  = SEL_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [SEL_W-1:0]  rd_addr,
  output logic [REG_W-1:0]  rdata,
  input  logic [HASH_W-1:0] idx_i,
  output logic              hit_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] words;
  logic [SEL_W-1:0]               sel;
  logic [BIT_W-1:0]               bitpos;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && (wr_addr == SEL_W'(r)))
        word_q <= wdata;
    end
    assign words[r] = word_q;
  end

  assign rdata  = words[rd_addr];
  assign sel    = idx_i[HASH_W-1 -: SEL_W];
  assign bitpos = BIT_W'(REG_W - 1) - idx_i[BIT_W-1:0];
  assign hit_o  = words[sel][bitpos];
endmodule

// File: rtl/mhf_group_filter.sv
module mhf_group_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_REGS   = 8,
  parameter int REG_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_start,
  input  logic [7:0]                  in_data,
  input  logic                        reg_wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] reg_wr_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  input  logic [$clog2(NUM_REGS)-1:0] reg_rd_addr,
  output logic [REG_W-1:0]            reg_rdata,
  output logic                        dec_valid,
  output logic                        dec_group,
  output logic                        dec_accept
);
  localparam int HASH_W = $clog2(NUM_REGS) + $clog2(REG_W);

  logic             fin, grp, hit;
  logic [CRC_W-1:0] crc;

  mhf_addr_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_data  (in_data),
    .fin_o    (fin),
    .grp_o    (grp),
    .crc_o    (crc)
  );

  // Table read and lookup see the pre-write contents in the same cycle
  mhf_hash_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wdata   (reg_wdata),
    .rd_addr (reg_rd_addr),
    .rdata   (reg_rdata),
    .idx_i   (crc[CRC_W-1 -: HASH_W]),
    .hit_o   (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_group  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= fin;
      dec_group  <= fin && grp;
      dec_accept <= fin && grp && hit;
    end
  end
endmodule

// File: rtl/mhf_group_filter_chk.sv
module mhf_group_filter_chk #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        reg_wr_en,
  input logic [$clog2(NUM_REGS)-1:0] reg_wr_addr,
  input logic [REG_W-1:0]            reg_wdata,
  input logic [$clog2(NUM_REGS)-1:0] reg_rd_addr,
  input logic [REG_W-1:0]            reg_rdata,
  input logic                        dec_valid,
  input logic                        dec_group,
  input logic                        dec_accept
);
  AST_DEC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R4

  AST_DEC_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid)); // R4

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_group && !dec_accept)); // R4

  AST_NONGROUP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_group) |-> !dec_accept); // R5

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr_en) && (reg_rd_addr == $past(reg_wr_addr)))
      |-> (reg_rdata == $past(reg_wdata))); // R9
endmodule

bind mhf_group_filter mhf_group_filter_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) chk_i (.*);

// File: tb/mhf_group_filter_tb_top.sv
`timescale 1ns/1ps
module mhf_group_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_start = 1'b0;
  logic [7:0]  in_data = '0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0, reg_rd_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        dec_valid, dec_group, dec_accept;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mhf_group_filter dut_i (.*);

  typedef struct packed {
    logic [47:0] addr;
    logic        set_bit;
    logic        grp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{48'h01005E000001, 1'b1, 1'b1},
    '{48'h01005E7FFFFA, 1'b1, 1'b1},
    '{48'h333300000001, 1'b0, 1'b1},
    '{48'h001122334455, 1'b1, 1'b0},
    '{48'h0180C200000E, 1'b1, 1'b1},
    '{48'hFFFFFFFFFFFF, 1'b1, 1'b1},
    '{48'h020000000001, 1'b1, 1'b0}
  };

  // Reference hash: reflected CRC, then bit-reverse of the low byte
  function automatic logic [7:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0]  r;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] by = a[47-8*k -: 8];
      for (int b = 0; b < 8; b++)
        c = ((c[0] ^ by[b]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    for (int b = 0; b < 8; b++) r[7-b] = c[b];
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic clear_tbl();
    for (int r = 0; r < 8; r++) wr(3'(r), 32'h0);
  endtask

  task automatic set_entry(input logic [7:0] idx);
    logic [31:0] w;
    rd(idx[7:5], w);
    w[31 - idx[4:0]] = 1'b1;
    wr(idx[7:5], w);
  endtask

  // Sends one address; optional gap and a write made with the sixth byte.
  task automatic send(input logic [47:0] a, input bit gap, input bit wlast,
                      input logic [2:0] wa, input logic [31:0] wd,
                      output bit early, output bit v, output bit g, output bit acc);
    early = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      early |= dec_valid;
      if (gap && i == 3) begin
        in_valid = 1'b0; in_start = 1'b0;
        @(negedge clk);
        early |= dec_valid;
      end
      in_valid = 1'b1; in_start = (i == 0); in_data = a[47-8*i -: 8];
      if (wlast && i == 5) begin
        reg_wr_en = 1'b1; reg_wr_addr = wa; reg_wdata = wd;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; reg_wr_en = 1'b0;
    v = dec_valid; g = dec_group; acc = dec_accept;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  ix;
    bit e, v, g, acc, seen;

    repeat (3) @(negedge clk);
    chk("R1", "dec_valid in reset", {31'b0, dec_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), w);
      chk("R1", "table after reset", w, 32'h0);
    end
    send(48'h01005E000001, 1'b0, 1'b0, 3'd0, 32'h0, e, v, g, acc);
    chk("R1", "accept after reset", {31'b0, acc}, 32'h0);

    // Vector table walk (R2, R3, R5, R6)
    foreach (VECS[n]) begin
      clear_tbl();
      ix = ref_idx(VECS[n].addr);
      if (VECS[n].set_bit) set_entry(ix);
      send(VECS[n].addr, 1'b0, 1'b0, 3'd0, 32'h0, e, v, g, acc);
      chk("R4", "valid strobe", {31'b0, v}, 32'h1);
      chk("R4", "no early strobe", {31'b0, e}, 32'h0);
      chk("R5", "group flag", {31'b0, g}, {31'b0, VECS[n].grp});
      chk("R6", "accept R2 hash", {31'b0, acc}, {31'b0, VECS[n].grp & VECS[n].set_bit});
      @(negedge clk);
      chk("R4", "strobe drops", {31'b0, dec_valid}, 32'h0);
    end

    // R3: all bits set except the selected one -> reject
    ix = ref_idx(48'h01005E000001);
    for (int r = 0; r < 8; r++)
      wr(3'(r), (r == int'(ix[7:5])) ? ~(32'h1 << (31 - ix[4:0])) : 32'hFFFFFFFF);
    send(48'h01005E000001, 1'b0, 1'b0, 3'd0, 32'h0, e, v, g, acc);
    chk("R3", "complement reject", {31'b0, acc}, 32'h0);

    // R9: full-word write and read-back
    wr(3'd5, 32'hA5C3_0F96);
    rd(3'd5, w);
    chk("R9", "read back", w, 32'hA5C3_0F96);

    // R8: gap inside an address
    clear_tbl();
    set_entry(ix);
    send(48'h01005E000001, 1'b1, 1'b0, 3'd0, 32'h0, e, v, g, acc);
    chk("R8", "gap accept", {31'b0, acc & v}, 32'h1);
    chk("R8", "gap no early strobe", {31'b0, e}, 32'h0);

    // R8: stray bytes with no start are ignored
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seen |= dec_valid;
      in_valid = 1'b1; in_start = 1'b0; in_data = 8'h01;
    end
    @(negedge clk); seen |= dec_valid;
    in_valid = 1'b0;
    @(negedge clk); seen |= dec_valid;
    chk("R8", "stray bytes no decision", {31'b0, seen}, 32'h0);

    // R7: restart after a partial address
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = (i == 0); in_data = 8'h00;
    end
    send(48'h01005E000001, 1'b0, 1'b0, 3'd0, 32'h0, e, v, g, acc);
    chk("R7", "restart no early strobe", {31'b0, e}, 32'h0);
    chk("R7", "restart accept", {31'b0, acc & v}, 32'h1);

    // R10: write with the sixth byte applies to the next lookup
    clear_tbl();
    send(48'h01005E000001, 1'b0, 1'b1, ix[7:5], 32'h1 << (31 - ix[4:0]), e, v, g, acc);
    chk("R10", "same-cycle set not seen", {31'b0, acc}, 32'h0);
    send(48'h01005E000001, 1'b0, 1'b0, 3'd0, 32'h0, e, v, g, acc);
    chk("R10", "set seen next lookup", {31'b0, acc}, 32'h1);
    send(48'h01005E000001, 1'b0, 1'b1, ix[7:5], 32'h0, e, v, g, acc);
    chk("R10", "same-cycle clear not seen", {31'b0, acc}, 32'h1);
    send(48'h01005E000001, 1'b0, 1'b0, 3'd0, 32'h0, e, v, g, acc);
    chk("R10", "clear seen next lookup", {31'b0, acc}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule